// File: doc/BRIEF.md
# Gaussian Kernel Neuron

This block produces one weighted kernel term of a support-vector classifier that works on 3×3 binary pixel patches. It covers a single input dimension. Each call takes a support-vector word and a test word for the current dimension, plus the same pair for the neighbouring dimension. The caller picks that neighbour: it is the next dimension, and the last dimension pairs with the first. From these the block forms a pair distance, maps it through a decaying exponential that already includes that dimension's width, and scales the result by the alpha coefficient of the machine currently being evaluated. Summing the terms over dimensions and machines, adding the bias and taking the sign are left to the surrounding datapath.

The work is split over three registered stages, and each stage has its own load enable. Stage one captures two saturated squared differences together with the dimension index. Stage two adds the squares, takes the integer square root, and reads the exponential table. Stage three multiplies the table value by alpha. The controller can step the stages one at a time, or hold all three enables high so that one term leaves the block per cycle. The exponential table is a parameter, so each dimension's kernel width is fixed at build time and never appears on a port.

Top module: `gauss_kernel_neuron`

## Requirements
- R1: A cycle with `rst_i` high clears every stage register, so `term_o` reads 0. A stage-three load that follows before any new stage-two load also yields 0.
- R2: On an edge with `ld_sq_i` high, stage one stores (sv_cur−tv_cur)² and (sv_nbr−tv_nbr)². The operands are 18-bit two's complement, and each square is clamped to 262143 (2^18−1).
- R3: A stage keeps its content on an edge where its enable is low. `term_o` changes only on an edge where `ld_mul_i` is high.
- R4: Stage two adds the two stored squares and clamps the sum to 262143. It then takes the floor of the square root, which lies in 0..511.
- R5: The table entry comes from row d and column k. Row d is the dimension index captured with `ld_sq_i`, in the range 0..8. Column k is bits [8:4] of the root. Entry (d,k) is the 18-bit unsigned word at bits [(d·32+k)·18 +: 18] of the `EXP_LUT` parameter, and it is stored on an edge with `ld_exp_i` high.
- R6: On an edge with `ld_mul_i` high, `term_o` becomes floor(alpha·e / 2^16), where alpha is the value on `alpha_i` at that edge and e is the stored table word.
- R7: When all three enables stay high, a new term is accepted every cycle. The term for inputs presented before edge n appears on `term_o` after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high, clears all stage registers |
| ld_sq_i | input | 1 | Stage-one load: squared differences and dimension index |
| ld_exp_i | input | 1 | Stage-two load: root and exponential lookup |
| ld_mul_i | input | 1 | Stage-three load: alpha product |
| dim_i | input | 4 | Dimension index 0..8 of the current term |
| sv_cur_i | input | 18 | Support-vector word, current dimension (signed) |
| tv_cur_i | input | 18 | Test word, current dimension (signed) |
| sv_nbr_i | input | 18 | Support-vector word, neighbouring dimension (signed) |
| tv_nbr_i | input | 18 | Test word, neighbouring dimension (signed) |
| alpha_i | input | 18 | Alpha coefficient of the current machine (signed, 16 fraction bits) |
| term_o | output | 18 | Weighted kernel term (signed, 16 fraction bits) |

## Verification
The assertions rely on two conditions. First, the dimension index is below nine on every stage-one load. Second, the table parameter holds values no greater than 1.0 (65536), so the product can never exceed alpha in magnitude. The stimulus draws dimensions modulo nine and loads a table built by repeated multiplication by a decay factor below one, starting from 1.0. Both conditions therefore hold even in the pseudo-random runs, including operands at full scale that drive the squares and the sum into saturation.

// File: rtl/gauss_kernel_neuron.sv
module gauss_kernel_neuron #(
  parameter int DW    = 18,
  parameter int FRAC  = 16,
  parameter int NDIM  = 9,
  parameter int IDX_W = 5,
  parameter int DIM_W = $clog2(NDIM),
  parameter logic [NDIM*(1<<IDX_W)*DW-1:0] EXP_LUT = {(NDIM*(1<<IDX_W)){18'h08000}}
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 ld_sq_i,
  input  logic                 ld_exp_i,
  input  logic                 ld_mul_i,
  input  logic [DIM_W-1:0]     dim_i,
  input  logic signed [DW-1:0] sv_cur_i,
  input  logic signed [DW-1:0] tv_cur_i,
  input  logic signed [DW-1:0] sv_nbr_i,
  input  logic signed [DW-1:0] tv_nbr_i,
  input  logic signed [DW-1:0] alpha_i,
  output logic signed [DW-1:0] term_o
);

  localparam int RW    = (DW + 1) / 2;
  localparam int LUT_N = 1 << IDX_W;
  localparam int PW    = 2 * DW + 2;

  logic signed [DW:0]   diff_a, diff_b;
  logic signed [PW-1:0] pow_a, pow_b;
  logic [DW-1:0]        sq_a, sq_b, sq_a_sat, sq_b_sat;
  logic [DIM_W-1:0]     dim_q;
  logic [DW:0]          sum_raw;
  logic [DW-1:0]        sum_sat;
  logic [RW-1:0]        root;
  logic [IDX_W-1:0]     bin;
  logic [DW-1:0]        e_sel, e_q;
  logic signed [2*DW:0] prod;

  // stage 1: paired squared differences, clamped
  assign diff_a   = DW'(sv_cur_i) - DW'(tv_cur_i) == 0 ? '0 : {sv_cur_i[DW-1], sv_cur_i} - {tv_cur_i[DW-1], tv_cur_i};
  assign diff_b   = {sv_nbr_i[DW-1], sv_nbr_i} - {tv_nbr_i[DW-1], tv_nbr_i};
  assign pow_a    = PW'(diff_a) * PW'(diff_a);
  assign pow_b    = PW'(diff_b) * PW'(diff_b);
  assign sq_a_sat = (|pow_a[PW-1:DW]) ? '1 : pow_a[DW-1:0];
  assign sq_b_sat = (|pow_b[PW-1:DW]) ? '1 : pow_b[DW-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sq_a  <= '0;
      sq_b  <= '0;
      dim_q <= '0;
    end else if (ld_sq_i) begin
      sq_a  <= sq_a_sat;
      sq_b  <= sq_b_sat;
      dim_q <= dim_i;
    end
  end

  // stage 2: clamped sum, integer root, per-dimension exponential table
  assign sum_raw = {1'b0, sq_a} + {1'b0, sq_b};
  assign sum_sat = sum_raw[DW] ? '1 : sum_raw[DW-1:0];

  always_comb begin
    logic [RW-1:0]   cand;
    logic [2*RW-1:0] cand_sq;
    root = '0;
    for (int i = RW - 1; i >= 0; i--) begin
      cand    = root | (RW'(1) << i);
      cand_sq = (2*RW)'(cand) * (2*RW)'(cand);
      if (cand_sq <= (2*RW)'(sum_sat)) root = cand;
    end
  end

  assign bin   = root[RW-1 -: IDX_W];
  assign e_sel = EXP_LUT[(int'(dim_q) * LUT_N + int'(bin)) * DW +: DW];

  always_ff @(posedge clk_i) begin
    if (rst_i)         e_q <= '0;
    else if (ld_exp_i) e_q <= e_sel;
  end

  // stage 3: alpha product
  assign prod = (2*DW+1)'(alpha_i) * (2*DW+1)'($signed({1'b0, e_q}));

  always_ff @(posedge clk_i) begin
    if (rst_i)         term_o <= '0;
    else if (ld_mul_i) term_o <= DW'(prod >>> FRAC);
  end

  function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
    logic signed [DW:0] w;
    w = {v[DW-1], v};
    return w[DW] ? -w : w;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (term_o == '0 && e_q == '0 && sq_a == '0 && sq_b == '0));

  a_r2_equal_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_sq_i && sv_cur_i == tv_cur_i) |=> (sq_a == '0));

  a_r3_hold_output: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_mul_i |=> $stable(term_o));

  a_r3_hold_exp: assert property (@(posedge clk_i) disable iff (rst_i)
    !ld_exp_i |=> $stable(e_q));

  a_r5_dim_range: assert property (@(posedge clk_i) disable iff (rst_i)
    ld_sq_i |-> (dim_i < DIM_W'(NDIM)));

  a_r6_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    ld_mul_i |=> (mag(term_o) <= mag($past(alpha_i))));

endmodule

// File: tb/test_gauss_kernel_neuron.sv
module test_gauss_kernel_neuron;

  localparam int DW = 18, NDIM = 9, LUT_N = 32, BIN = 16;
  localparam int TOTAL = NDIM * LUT_N * DW;

  function automatic logic [TOTAL-1:0] mk_lut();
    logic [TOTAL-1:0] t;
    t = '0;
    for (int d = 0; d < NDIM; d++) begin
      longint sig = 24 + 12 * d;
      longint m = 65536 - 65536 / sig;
      longint e = 65536;
      for (int r = 0; r < LUT_N * BIN; r++) begin
        if (r % BIN == 8) t[(d * LUT_N + r / BIN) * DW +: DW] = e[DW-1:0];
        e = (e * m) >> 16;
      end
    end
    return t;
  endfunction

  localparam logic [TOTAL-1:0] LUT = mk_lut();

  logic clk = 0, rst = 1, ld_sq = 0, ld_exp = 0, ld_mul = 0;
  logic [3:0] dim = 0;
  logic signed [DW-1:0] svc = 0, tvc = 0, svn = 0, tvn = 0, alpha = 0;
  logic signed [DW-1:0] term;

  always #2 clk = ~clk;

  gauss_kernel_neuron #(.EXP_LUT(LUT)) i_gauss_kernel_neuron (
    .clk_i(clk), .rst_i(rst), .ld_sq_i(ld_sq), .ld_exp_i(ld_exp), .ld_mul_i(ld_mul),
    .dim_i(dim), .sv_cur_i(svc), .tv_cur_i(tvc), .sv_nbr_i(svn), .tv_nbr_i(tvn),
    .alpha_i(alpha), .term_o(term));

  typedef struct { int sc; int tc; int sn; int tn; int d; int al; } item_t;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  item_t pend[$];
  string pend_tag[$];
  int q_due[$];
  longint q_exp[$];
  string q_tag[$];
  longint last_exp;
  int seed = 7;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint model(item_t it);
    longint a, b, s, r, k, e, p;
    a = longint'(it.sc - it.tc) * longint'(it.sc - it.tc);
    b = longint'(it.sn - it.tn) * longint'(it.sn - it.tn);
    if (a > 262143) a = 262143;
    if (b > 262143) b = 262143;
    s = a + b;
    if (s > 262143) s = 262143;
    r = 0;
    while ((r + 1) * (r + 1) <= s) r++;
    k = r >> 4;
    e = longint'(LUT[(it.d * LUT_N + int'(k)) * DW +: DW]);
    p = longint'(it.al) * e;
    return p >>> 16;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(q_tag[0], longint'(term), q_exp[0]);
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  function automatic item_t mk(int sc, int tc, int sn, int tn, int d, int al);
    item_t it;
    it.sc = sc; it.tc = tc; it.sn = sn; it.tn = tn; it.d = d; it.al = al;
    return it;
  endfunction

  task automatic add(item_t it, string tag);
    pend.push_back(it);
    pend_tag.push_back(tag);
  endtask

  task automatic drive(item_t it);
    svc = DW'(it.sc); tvc = DW'(it.tc); svn = DW'(it.sn); tvn = DW'(it.tn);
    dim = 4'(it.d);
  endtask

  // streaming driver: all enables high, scoreboard entries due three edges later (R7)
  task automatic flush();
    int n = pend.size();
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      ld_sq = 1; ld_exp = 1; ld_mul = 1;
      if (i < n) begin
        drive(pend[i]);
        q_due.push_back(cyc + 3);
        q_exp.push_back(model(pend[i]));
        q_tag.push_back(pend_tag[i]);
      end
      if (i >= 2) alpha = DW'(pend[i-2].al);
    end
    @(negedge clk);
    ld_sq = 0; ld_exp = 0; ld_mul = 0;
    last_exp = model(pend[n-1]);
    pend.delete();
    pend_tag.delete();
    repeat (2) @(negedge clk);
  endtask

  function automatic int rnd(int span);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffffff) % span;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    item_t st, st2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset output", longint'(term), 0);

    add(mk(0, 0, 0, 0, 0, 1000), "R4 zero distance");
    add(mk(131071, -131072, 131071, -131072, 8, 65535), "R2 square clamp");
    add(mk(300, -211, 0, 0, 4, 32000), "R4 sum below clamp");
    add(mk(5, 2, -7, 1, 2, -131072), "R6 most negative alpha");
    add(mk(511, 0, 0, 0, 1, 70000), "R5 top column");
    for (int d = 0; d < NDIM; d++)
      add(mk(d * 9, -d * 4, 3 - d, d, d, (d % 2) ? -40000 + d * 999 : 50000 - d * 777), "R5 row per dimension");
    flush();

    for (int i = 0; i < 16; i++) begin
      int big = (i % 4 == 0);
      int sp = big ? 262144 : 600;
      int off = big ? 131072 : 300;
      add(mk(rnd(sp) - off, rnd(sp) - off, rnd(sp) - off, rnd(sp) - off,
             rnd(NDIM), rnd(262144) - 131072), "R7 streamed random");
    end
    flush();

    // R3: enables low, inputs change, output keeps last term
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      svc = DW'(rnd(1000)); tvc = DW'(-rnd(1000)); alpha = DW'(rnd(60000)); dim = 4'(rnd(NDIM));
    end
    @(negedge clk);
    chk("R3 hold with enables low", longint'(term), last_exp);

    // R3/R5/R6: stages stepped one at a time, dimension captured at stage one
    st = mk(40, -20, 17, 3, 3, 45000);
    @(negedge clk); drive(st); ld_sq = 1;
    @(negedge clk); ld_sq = 0; svc = 18'sd9; dim = 4'd7; ld_exp = 1;
    @(negedge clk); ld_exp = 0; ld_sq = 0;
    chk("R3 no output change before stage-three load", longint'(term), last_exp);
    alpha = DW'(st.al); ld_mul = 1;
    @(negedge clk); ld_mul = 0;
    chk("R5 row from captured dimension", longint'(term), model(st));
    @(negedge clk); alpha = -18'sd5000; ld_mul = 1;
    @(negedge clk); ld_mul = 0;
    st.al = -5000;
    chk("R6 alpha sampled at stage three", longint'(term), model(st));

    // R1: reset with a loaded pipeline
    st2 = mk(100, -90, 60, 2, 6, 30000);
    @(negedge clk); drive(st2); ld_sq = 1; ld_exp = 1;
    @(negedge clk); ld_sq = 0; ld_exp = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset clears output", longint'(term), 0);
    alpha = 18'sd30000; ld_mul = 1;
    @(negedge clk); ld_mul = 0;
    chk("R1 cleared table register", longint'(term), 0);
    ld_exp = 1;
    @(negedge clk); ld_exp = 0; ld_mul = 1;
    @(negedge clk); ld_mul = 0;
    chk("R1 cleared squares and dimension", longint'(term), model(mk(0, 0, 0, 0, 0, 30000)));

    repeat (3) @(negedge clk);
    if (q_due.size() != 0) chk("R7 scoreboard drained", q_due.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule